// File: doc/BRIEF.md
# Addressed Attribute Bus Controller

This block carries runtime parameter writes and reads from a host to a set of processing components over one shared, time-multiplexed word bus. The host first loads a component address, a starting register address, a word count and up to `MAXW` data words into the controller. It then writes a control word that starts the transfer. The controller decodes the component address and pulses only that component's own strobe line, once per bus word. It places a header word (direction, count, start register) on the shared bus, followed by the data words. Each word is held for `HOLD` cycles, so the shared bus can be treated as a multicycle path.

Each strobe line passes through a `DLY`-stage register chain before it reaches its component. Each component contains one reusable endpoint. The endpoint samples the shared bus only in the cycle in which its delayed strobe arrives. From the header it rebuilds a local register address, a word counter and a direction. It then writes incoming words into its own register file, or returns register contents on a return path that is zero whenever it is not answering. Register maps are local, so several copies of the endpoint reuse the same register addresses under different component addresses. Every component also has an event input. The endpoint forwards it to the controller, where it sets a sticky flag that the host clears by reading the flag word.

Controller states are C_IDLE, C_HEAD and C_DATA. A start command moves C_IDLE to C_HEAD. At the end of the header word, C_HEAD moves to C_IDLE when the count is zero and to C_DATA otherwise. At the end of the last data word, C_DATA moves to C_IDLE. Endpoint states are E_HDR, E_WR and E_RD. A strobed header with a nonzero count moves E_HDR to E_WR (write) or E_RD (read). The strobe of the last word returns E_WR or E_RD to E_HDR. `NREG` must be a power of two, and `DLY` must not exceed `HOLD-2`.

Top module: `attr_bus_top`

## Requirements
- R1: After reset, `done` is 1, `evt_flags` is 0 and every slot of the data buffer reads 0 through `rd_word`.
- R2: At most one strobe line is active in any cycle, and it is the one for the decoded component address.
- R3: A host write with `cmd_sel`=0 loads the component address, 1 the start register, 2 the word count and 4 the control word. A value of 3 pushes one data word into the next buffer slot (slots fill from 0, at most `MAXW`). A control word with bit 0 set starts a transfer; bit 1 = 1 selects a read and 0 a write. At the start edge `done` falls. It rises exactly (1+N)*`HOLD` clock edges later, where N is the word count (limited to `MAXW`). The buffer fill position returns to slot 0 at the start.
- R4: A write transfer of N words stores buffer slots 0..N-1 in consecutive registers of the target component, from the start register upward, wrapping modulo `NREG`.
- R5: A read transfer of N words places the contents of consecutive target registers (start register upward) into buffer slots 0..N-1, and `rd_word` shows slot `rd_idx`.
- R6: Register addresses are local to each component: a write to register r of one component leaves register r of every other component unchanged.
- R7: While `done` is 0, every host command write (address, register, count, data push, control) is ignored.
- R8: When `comp_evt[i]` is sampled high at a clock edge, `evt_flags[i]` is 1 after the second following edge and stays 1 until cleared.
- R9: Sampling `evt_rd` high clears all event flags at that edge, except a flag whose forwarded event arrives at that same edge: that flag stays set.
- R10: A component address of `NCOMP` or more drives no strobe. The transfer still runs its full length, writes change no component, and reads return 0.
- R11: A word count of 0 sends only the header (`done` low for `HOLD` edges) and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Host command write strobe |
| cmd_sel | input | 3 | Host command target (0 comp, 1 reg, 2 count, 3 data push, 4 control) |
| cmd_wdata | input | DW | Host command value |
| rd_idx | input | $clog2(MAXW) | Buffer slot shown on `rd_word` |
| evt_rd | input | 1 | Read-and-clear of the event flag word |
| comp_evt | input | NCOMP | Event request from each component |
| done | output | 1 | Controller idle and ready for a command |
| evt_flags | output | NCOMP | Sticky per-component event flags |
| rd_word | output | DW | Buffer slot selected by `rd_idx` |

## Verification
Two functions meet in one cycle in the event path: a forwarded event reaches the flag register at the same edge as a host read-and-clear. The bench provokes this by raising one component's event, then asserting `evt_rd` exactly one cycle later, so that both are sampled together. The result is judged against a behavioural flag model that is compared on every clock, and by a direct check that only the new flag survives. A second overlap, host commands arriving while a transfer is running, is provoked by issuing address, data and start writes mid-transfer. It is judged by the `done` timing model and by reading back the register that the unaltered command set must have reached.

// File: rtl/attr_pkg.sv
package attr_pkg;
    typedef enum logic [1:0] {
        C_IDLE,
        C_HEAD,
        C_DATA
    } ctrl_state_t;

    typedef enum logic [1:0] {
        E_HDR,
        E_WR,
        E_RD
    } ep_state_t;

    localparam logic [2:0] SEL_COMP = 3'd0;
    localparam logic [2:0] SEL_REG  = 3'd1;
    localparam logic [2:0] SEL_CNT  = 3'd2;
    localparam logic [2:0] SEL_DATA = 3'd3;
    localparam logic [2:0] SEL_CTRL = 3'd4;
endpackage

// File: rtl/attr_strobe_delay.sv
module attr_strobe_delay #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (DLY == 0) begin : g_wire
            assign q = d;
        end else begin : g_chain
            logic [DLY-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    stage_q[0] <= d;
                    for (int i = 1; i < DLY; i++) begin
                        stage_q[i] <= stage_q[i-1];
                    end
                end
            end
            assign q = stage_q[DLY-1];
        end
    endgenerate
endmodule

// File: rtl/attr_endpoint.sv
module attr_endpoint
    import attr_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 16,
    parameter int MAXW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strb_d,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] rtn_out,
    input  logic          evt_src,
    output logic          evt_out
);
    localparam int RAW = $clog2(NREG);
    localparam int CW  = $clog2(MAXW + 1);

    ep_state_t         state_q, state_d;
    logic [RAW-1:0]    addr_q;
    logic [CW-1:0]     left_q;
    logic [DW-1:0]     regs_q [NREG];
    logic [DW-1:0]     rtn_q;
    logic              evt_q;
    logic [CW-1:0]     hdr_cnt;
    logic              hdr_dir;

    assign hdr_cnt = bus_in[RAW+CW-1:RAW];
    assign hdr_dir = bus_in[DW-1];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_HDR: if (strb_d && hdr_cnt != '0) state_d = hdr_dir ? E_RD : E_WR;
            E_WR:  if (strb_d && left_q == CW'(1)) state_d = E_HDR;
            E_RD:  if (strb_d && left_q == CW'(1)) state_d = E_HDR;
            default: state_d = E_HDR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= E_HDR;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
            rtn_q  <= '0;
            evt_q  <= 1'b0;
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            rtn_q <= '0;
            evt_q <= evt_src;
            if (strb_d) begin
                unique case (state_q)
                    E_HDR: begin
                        addr_q <= bus_in[RAW-1:0];
                        left_q <= hdr_cnt;
                    end
                    E_WR: begin
                        regs_q[addr_q] <= bus_in;
                        addr_q <= addr_q + RAW'(1);
                        left_q <= left_q - CW'(1);
                    end
                    E_RD: begin
                        rtn_q  <= regs_q[addr_q];
                        addr_q <= addr_q + RAW'(1);
                        left_q <= left_q - CW'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rtn_out = rtn_q;
    assign evt_out = evt_q;

    // R5: the return path carries data only in the cycle after a delayed strobe
    p_rtn_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rtn_q != '0) |-> $past(strb_d));
endmodule

// File: rtl/attr_ctrl.sv
module attr_ctrl
    import attr_pkg::*;
#(
    parameter int NCOMP = 4,
    parameter int NREG  = 8,
    parameter int DW    = 16,
    parameter int MAXW  = 4,
    parameter int HOLD  = 4,
    parameter int SAMP  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_we,
    input  logic [2:0]              cmd_sel,
    input  logic [DW-1:0]           cmd_wdata,
    input  logic [$clog2(MAXW)-1:0] rd_idx,
    input  logic                    evt_rd,
    output logic                    done,
    output logic [NCOMP-1:0]        evt_flags,
    output logic [DW-1:0]           rd_word,
    output logic [DW-1:0]           bus_out,
    output logic [NCOMP-1:0]        strb_out,
    input  logic [DW-1:0]           rtn_in,
    input  logic [NCOMP-1:0]        evt_in
);
    localparam int RAW = $clog2(NREG);
    localparam int CW  = $clog2(MAXW + 1);
    localparam int CAW = $clog2(NCOMP) + 1;
    localparam int HCW = $clog2(HOLD);
    localparam int IW  = $clog2(MAXW);

    ctrl_state_t       state_q, state_d;
    logic [CAW-1:0]    comp_q;
    logic [RAW-1:0]    reg_q;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     ptr_q;
    logic [DW-1:0]     buf_q [MAXW];
    logic [HCW-1:0]    hcnt_q;
    logic [CW-1:0]     widx_q;
    logic [CW-1:0]     n_q;
    logic              dir_q;
    logic [NCOMP-1:0]  tgt_q;
    logic [NCOMP-1:0]  strb_q;
    logic [DW-1:0]     bus_q;
    logic              done_q;
    logic [NCOMP-1:0]  flags_q;

    logic              host_ok;
    logic              start_ok;
    logic              last_slot;
    logic              more_words;
    logic [CW-1:0]     n_eff;
    logic [NCOMP-1:0]  sel_vec;
    logic [DW-1:0]     hdr_word;

    assign host_ok    = cmd_we && done_q;
    assign start_ok   = host_ok && (cmd_sel == SEL_CTRL) && cmd_wdata[0];
    assign last_slot  = (hcnt_q == HCW'(HOLD - 1));
    assign more_words = (state_q == C_HEAD) ? (n_q != '0) : (widx_q != n_q);
    assign n_eff      = (cnt_q > CW'(MAXW)) ? CW'(MAXW) : cnt_q;

    always_comb begin
        for (int i = 0; i < NCOMP; i++) sel_vec[i] = (comp_q == CAW'(i));
    end

    always_comb begin
        hdr_word                 = '0;
        hdr_word[RAW-1:0]        = reg_q;
        hdr_word[RAW+CW-1:RAW]   = n_eff;
        hdr_word[DW-1]           = cmd_wdata[1];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE: if (start_ok) state_d = C_HEAD;
            C_HEAD: if (last_slot) state_d = (n_q == '0) ? C_IDLE : C_DATA;
            C_DATA: if (last_slot && widx_q == n_q) state_d = C_IDLE;
            default: state_d = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comp_q  <= '0;
            reg_q   <= '0;
            cnt_q   <= '0;
            ptr_q   <= '0;
            hcnt_q  <= '0;
            widx_q  <= '0;
            n_q     <= '0;
            dir_q   <= 1'b0;
            tgt_q   <= '0;
            strb_q  <= '0;
            bus_q   <= '0;
            done_q  <= 1'b1;
            flags_q <= '0;
            for (int i = 0; i < MAXW; i++) buf_q[i] <= '0;
        end else begin
            strb_q  <= '0;
            flags_q <= (evt_rd ? '0 : flags_q) | evt_in;
            if (host_ok) begin
                case (cmd_sel)
                    SEL_COMP: comp_q <= cmd_wdata[CAW-1:0];
                    SEL_REG:  reg_q  <= cmd_wdata[RAW-1:0];
                    SEL_CNT:  cnt_q  <= cmd_wdata[CW-1:0];
                    SEL_DATA: if (ptr_q < CW'(MAXW)) begin
                        buf_q[IW'(ptr_q)] <= cmd_wdata;
                        ptr_q <= ptr_q + CW'(1);
                    end
                    SEL_CTRL: if (cmd_wdata[0]) begin
                        dir_q  <= cmd_wdata[1];
                        n_q    <= n_eff;
                        widx_q <= '0;
                        hcnt_q <= '0;
                        bus_q  <= hdr_word;
                        tgt_q  <= sel_vec;
                        strb_q <= sel_vec;
                        done_q <= 1'b0;
                        ptr_q  <= '0;
                    end
                    default: ;
                endcase
            end
            if (state_q != C_IDLE) begin
                hcnt_q <= hcnt_q + HCW'(1);
                if (dir_q && state_q == C_DATA && hcnt_q == HCW'(SAMP)) begin
                    buf_q[IW'(widx_q - CW'(1))] <= rtn_in;
                end
                if (last_slot) begin
                    hcnt_q <= '0;
                    if (more_words) begin
                        widx_q <= widx_q + CW'(1);
                        bus_q  <= dir_q ? '0 : buf_q[IW'(widx_q)];
                        strb_q <= tgt_q;
                    end else begin
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign done      = done_q;
    assign evt_flags = flags_q;
    assign rd_word   = buf_q[rd_idx];
    assign bus_out   = bus_q;
    assign strb_out  = strb_q;

    // R2: never more than one component strobed
    p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb_q));
    // R7: host writes during a transfer leave the command set untouched
    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !done_q) |=> ($stable(comp_q) && $stable(reg_q) &&
                                 $stable(cnt_q) && $stable(ptr_q)));
    // R3: a bus word stays put for its whole hold window
    p_bus_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != C_IDLE && !last_slot) |=> $stable(bus_q));
    // R3: done returns only at the end of a running transfer
    p_done_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(state_q) != C_IDLE));
    // R8: a forwarded event is always captured in the flags
    p_evt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(evt_in)) == $past(evt_in)));
endmodule

// File: rtl/attr_bus_top.sv
module attr_bus_top #(
    parameter int NCOMP = 4,
    parameter int NREG  = 8,
    parameter int DW    = 16,
    parameter int MAXW  = 4,
    parameter int HOLD  = 4,
    parameter int DLY   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_we,
    input  logic [2:0]              cmd_sel,
    input  logic [DW-1:0]           cmd_wdata,
    input  logic [$clog2(MAXW)-1:0] rd_idx,
    input  logic                    evt_rd,
    input  logic [NCOMP-1:0]        comp_evt,
    output logic                    done,
    output logic [NCOMP-1:0]        evt_flags,
    output logic [DW-1:0]           rd_word
);
    localparam int SAMP = DLY + 1;

    logic [DW-1:0]    shared_bus;
    logic [NCOMP-1:0] strb_raw;
    logic [NCOMP-1:0] strb_dly;
    logic [NCOMP-1:0] ep_evt;
    logic [DW-1:0]    rtn_each [NCOMP];
    logic [DW-1:0]    rtn_all;

    attr_ctrl #(
        .NCOMP(NCOMP), .NREG(NREG), .DW(DW),
        .MAXW(MAXW), .HOLD(HOLD), .SAMP(SAMP)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_sel   (cmd_sel),
        .cmd_wdata (cmd_wdata),
        .rd_idx    (rd_idx),
        .evt_rd    (evt_rd),
        .done      (done),
        .evt_flags (evt_flags),
        .rd_word   (rd_word),
        .bus_out   (shared_bus),
        .strb_out  (strb_raw),
        .rtn_in    (rtn_all),
        .evt_in    (ep_evt)
    );

    generate
        for (genvar g = 0; g < NCOMP; g++) begin : g_comp
            attr_strobe_delay #(.DLY(DLY)) u_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (strb_raw[g]),
                .q     (strb_dly[g])
            );
            attr_endpoint #(.NREG(NREG), .DW(DW), .MAXW(MAXW)) u_ep (
                .clk     (clk),
                .rst_n   (rst_n),
                .strb_d  (strb_dly[g]),
                .bus_in  (shared_bus),
                .rtn_out (rtn_each[g]),
                .evt_src (comp_evt[g]),
                .evt_out (ep_evt[g])
            );
        end
    endgenerate

    always_comb begin
        rtn_all = '0;
        for (int i = 0; i < NCOMP; i++) rtn_all = rtn_all | rtn_each[i];
    end
endmodule

// File: tb/attr_bus_top_tb.sv
`timescale 1ns/100ps
module attr_bus_top_tb;
    localparam int NCOMP = 4;
    localparam int NREG  = 8;
    localparam int DW    = 16;
    localparam int MAXW  = 4;
    localparam int HOLD  = 4;
    localparam int DLY   = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_we = 1'b0;
    logic [2:0]       cmd_sel = 3'd0;
    logic [DW-1:0]    cmd_wdata = '0;
    logic [1:0]       rd_idx = '0;
    logic             evt_rd = 1'b0;
    logic [NCOMP-1:0] comp_evt = '0;
    logic             done;
    logic [NCOMP-1:0] evt_flags;
    logic [DW-1:0]    rd_word;

    integer total = 0;
    integer bad = 0;
    bit     finished = 0;

    attr_bus_top #(.NCOMP(NCOMP), .NREG(NREG), .DW(DW),
                   .MAXW(MAXW), .HOLD(HOLD), .DLY(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_sel(cmd_sel),
        .cmd_wdata(cmd_wdata), .rd_idx(rd_idx), .evt_rd(evt_rd),
        .comp_evt(comp_evt), .done(done), .evt_flags(evt_flags),
        .rd_word(rd_word)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    integer          m_comp, m_reg, m_cnt, m_ptr, m_left;
    bit              m_done;
    logic [DW-1:0]   m_buf [MAXW];
    logic [DW-1:0]   m_regs [NCOMP][NREG];
    logic [NCOMP-1:0] m_flags, m_evq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_comp = 0; m_reg = 0; m_cnt = 0; m_ptr = 0; m_left = 0;
            m_done = 1;
            for (int i = 0; i < MAXW; i++) m_buf[i] = '0;
            for (int c = 0; c < NCOMP; c++)
                for (int r = 0; r < NREG; r++) m_regs[c][r] = '0;
            m_flags <= '0;
            m_evq   <= '0;
        end else begin
            m_flags <= (evt_rd ? '0 : m_flags) | m_evq;
            m_evq   <= comp_evt;
            if (m_left > 0) begin
                m_left = m_left - 1;
                if (m_left == 0) m_done = 1;
            end else if (cmd_we && m_done) begin
                case (cmd_sel)
                    3'd0: m_comp = cmd_wdata % 8;
                    3'd1: m_reg  = cmd_wdata % NREG;
                    3'd2: m_cnt  = cmd_wdata % 8;
                    3'd3: if (m_ptr < MAXW) begin
                        m_buf[m_ptr] = cmd_wdata;
                        m_ptr = m_ptr + 1;
                    end
                    3'd4: if (cmd_wdata[0]) begin
                        automatic int n = (m_cnt > MAXW) ? MAXW : m_cnt;
                        for (int i = 0; i < n; i++) begin
                            if (cmd_wdata[1])
                                m_buf[i] = (m_comp < NCOMP) ?
                                           m_regs[m_comp][(m_reg + i) % NREG] : '0;
                            else if (m_comp < NCOMP)
                                m_regs[m_comp][(m_reg + i) % NREG] = m_buf[i];
                        end
                        m_ptr  = 0;
                        m_done = 0;
                        m_left = (1 + n) * HOLD;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3/R7 done timing", {31'd0, done}, {31'd0, m_done});
            chk("R8/R9 flag model", {28'd0, evt_flags}, {28'd0, m_flags});
        end
    end

    task automatic hw(input logic [2:0] s, input logic [DW-1:0] d);
        @(negedge clk);
        cmd_we = 1'b1; cmd_sel = s; cmd_wdata = d;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_done;
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    task automatic xfer(input int comp, input int rg, input int cnt, input bit rd);
        hw(3'd0, DW'(comp));
        hw(3'd1, DW'(rg));
        hw(3'd2, DW'(cnt));
        hw(3'd4, rd ? 16'd3 : 16'd1);
        wait_done();
    endtask

    task automatic rd_chk(input int idx, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        rd_idx = 2'(idx);
        #1;
        chk(tag, {16'd0, rd_word}, {16'd0, exp});
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", {31'd0, done}, 32'd1);
        chk("R1 flags", {28'd0, evt_flags}, 32'd0);
        rd_chk(0, 16'h0, "R1 buffer");

        // R3 / R4 write burst, R6 separate map
        hw(3'd3, 16'hA1A1); hw(3'd3, 16'hB2B2); hw(3'd3, 16'hC3C3);
        xfer(0, 2, 3, 0);
        hw(3'd3, 16'hD4D4);
        xfer(1, 2, 1, 0);
        xfer(0, 2, 3, 1);
        rd_chk(0, 16'hA1A1, "R5 read slot0");
        rd_chk(1, 16'hB2B2, "R5 read slot1");
        rd_chk(2, 16'hC3C3, "R3 burst slot2");
        xfer(1, 2, 1, 1);
        rd_chk(0, 16'hD4D4, "R6 comp1 reg2");
        xfer(0, 2, 1, 1);
        rd_chk(0, 16'hA1A1, "R6 comp0 reg2 kept");

        // R4 wrap modulo NREG
        hw(3'd3, 16'h1006); hw(3'd3, 16'h1007); hw(3'd3, 16'h1000); hw(3'd3, 16'h1001);
        xfer(2, 6, 4, 0);
        xfer(2, 0, 2, 1);
        rd_chk(0, 16'h1000, "R4 wrap reg0");
        rd_chk(1, 16'h1001, "R4 wrap reg1");
        xfer(2, 6, 2, 1);
        rd_chk(0, 16'h1006, "R4 reg6");
        rd_chk(1, 16'h1007, "R4 reg7");

        // R11 zero count
        hw(3'd3, 16'h7777);
        xfer(3, 0, 0, 0);
        xfer(3, 0, 1, 1);
        rd_chk(0, 16'h0000, "R11 no write");

        // R7 commands while busy
        hw(3'd3, 16'h5555);
        hw(3'd0, 16'd0); hw(3'd1, 16'd0); hw(3'd2, 16'd1);
        hw(3'd4, 16'd1);
        hw(3'd0, 16'd1);
        hw(3'd3, 16'h9999);
        hw(3'd4, 16'd3);
        wait_done();
        hw(3'd4, 16'd3);
        wait_done();
        rd_chk(0, 16'h5555, "R7 busy ignored");

        // R10 out-of-range component
        hw(3'd3, 16'h1234);
        xfer(5, 0, 1, 0);
        xfer(1, 0, 1, 1);
        rd_chk(0, 16'h0000, "R10 no alias write");
        xfer(5, 2, 1, 1);
        rd_chk(0, 16'h0000, "R10 read zero");

        // R8 event capture
        @(negedge clk); comp_evt = 4'b0010;
        @(negedge clk); comp_evt = 4'b0000;
        @(negedge clk);
        #1 chk("R8 flag set", {28'd0, evt_flags}, 32'h2);
        repeat (3) @(negedge clk);
        chk("R8 flag sticky", {28'd0, evt_flags}, 32'h2);

        // R9 clear on read, and clear colliding with a new event
        @(negedge clk); evt_rd = 1'b1;
        @(negedge clk); evt_rd = 1'b0;
        #1 chk("R9 cleared", {28'd0, evt_flags}, 32'h0);
        @(negedge clk); comp_evt = 4'b0001;
        @(negedge clk); comp_evt = 4'b0000;
        repeat (2) @(negedge clk);
        comp_evt = 4'b0100;
        @(negedge clk); comp_evt = 4'b0000; evt_rd = 1'b1;
        @(negedge clk); evt_rd = 1'b0;
        #1 chk("R9 set beats clear", {28'd0, evt_flags}, 32'h4);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule